// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This unit sits between an execute stage and a 32-bit data memory that is addressed in bytes and stores words. It forms the effective address of each access by adding a sign-extended 16-bit displacement to a 32-bit base value. Base plus displacement is the only way it forms an address. For stores it copies byte or halfword data into every lane of the write word and raises only the byte-write enables of the lanes that the address selects. For loads it issues a read request. On the following cycle it takes the addressed byte or halfword out of the word the memory returns and extends it with sign or zero bits, as the request selected.

Byte order is big-endian: byte offset 0 is bits 31..24 of the memory word. A halfword at an odd address, or a word whose low two address bits are not zero, is misaligned. For such an access the unit raises a flag and does not issue a read or a write. The memory returns read data exactly one cycle after a read request.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr` always equals `base` plus `disp` sign-extended to 32 bits, modulo 2^32.
- R2: `misalign` is high only when `req_valid` is high and either the size is halfword (1) with address bit 0 set, or the size is word (2) or the spare code 3 with address bits 1..0 not zero. A byte access (size 0) is never misaligned.
- R3: `mem_wr_en` is high exactly for a valid, aligned store (`req_store`=1). `mem_byte_en` is all zero whenever `mem_wr_en` is low.
- R4: For a store, bit 3 of `mem_byte_en` covers data bits 31..24 and bit 0 covers bits 7..0. A byte store at offset k sets only bit 3-k. A halfword store sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store, or size code 3, sets 4'b1111.
- R5: When `mem_wr_en` is high, `mem_wdata` carries `store_data[7:0]` in all four lanes for a byte store, `store_data[15:0]` in both halves for a halfword store, and `store_data` unchanged for a word store.
- R6: `mem_rd_en` is high exactly for a valid, aligned load (`req_store`=0). It is never high together with `mem_wr_en`.
- R7: `ld_valid` is high in the cycle after `mem_rd_en` was high, and only then. In that cycle `ld_data` holds the addressed byte taken from bits 31-8k..24-8k of `mem_rdata`, the halfword at offset 0 (bits 31..16) or offset 2 (bits 15..0), or the whole word.
- R8: For byte and halfword loads, `req_unsigned`=1 fills the upper bits of `ld_data` with zeros. `req_unsigned`=0 fills them with copies of the top bit of the extracted value. The flag has no effect on word loads.
- R9: A misaligned load produces no `ld_valid` on the next cycle.
- R10: While reset is held and right after it, `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| req_unsigned | input | 1 | Zero-extend a sub-word load |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Read word, one cycle after the request |
| mem_addr | output | 32 | Effective byte address |
| mem_rd_en | output | 1 | Read request |
| mem_wr_en | output | 1 | Write request |
| mem_byte_en | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Misaligned access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench walks byte loads and stores through all four offsets and halfword accesses through both aligned offsets. A design with the lane order reversed, or one that treats the offset as little-endian, returns or writes the wrong byte. Loaded values are chosen with the top bit set so that a mix-up between sign and zero extension changes the upper bits. The bench also sends halfword and word accesses at every misaligned offset, so a design that still drives an enable, or a read that later reports a result, gets caught. Negative displacements that wrap past address zero expose a design that zero-extends the displacement.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANE_N = 4;
  localparam int WORD_W = 8 * LANE_N;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_SPARE = 2'd3
  } acc_size_e;

  // Lane mask, big-endian: bit 3 covers bits 31..24 (offset 0).
  function automatic logic [LANE_N-1:0] lane_mask(acc_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = 4'b1000 >> off;
      SZ_HALF: lane_mask = off[1] ? 4'b0011 : 4'b1100;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic is_misaligned(acc_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: is_misaligned = 1'b0;
      SZ_HALF: is_misaligned = off[0];
      default: is_misaligned = |off;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] replicate(acc_size_e sz, logic [WORD_W-1:0] d);
    case (sz)
      SZ_BYTE: replicate = {LANE_N{d[7:0]}};
      SZ_HALF: replicate = {(LANE_N/2){d[15:0]}};
      default: replicate = d;
    endcase
  endfunction

  // Shift the addressed item to the top of the word, then extend.
  function automatic logic [WORD_W-1:0] extract(acc_size_e sz, logic uns, logic [1:0] off,
                                                 logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] top;
    top = w << {off, 3'b000};
    case (sz)
      SZ_BYTE: extract = {{(WORD_W-8){top[WORD_W-1] & ~uns}}, top[WORD_W-1 -: 8]};
      SZ_HALF: extract = {{(WORD_W-16){top[WORD_W-1] & ~uns}}, top[WORD_W-1 -: 16]};
      default: extract = w;
    endcase
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  acc_size_e         req_size,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign eff_addr = base + disp_ext;
  assign misalign = req_valid & is_misaligned(req_size, eff_addr[1:0]);

  AST_BYTE_NEVER_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_size == SZ_BYTE) |-> !misalign); // R2
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !misalign); // R2
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  acc_size_e         req_size,
  input  logic [1:0]        off,
  input  logic [WORD_W-1:0] store_data,
  output logic [LANE_N-1:0] byte_en,
  output logic [WORD_W-1:0] wdata
);
  logic [LANE_N-1:0] mask;
  logic [WORD_W-1:0] rep;

  assign mask = lane_mask(req_size, off);
  assign rep  = replicate(req_size, store_data);

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    assign byte_en[i]           = wr_go & mask[i];
    assign wdata[8*i+7 -: 8]    = rep[8*i+7 -: 8];
  end

  AST_BE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |-> (byte_en == '0)); // R3
  AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && req_size == SZ_BYTE) |-> $onehot(byte_en)); // R4
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && req_size == SZ_HALF) |-> ($countones(byte_en) == 2)); // R4
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  acc_size_e         req_size,
  input  logic              req_unsigned,
  input  logic [1:0]        off,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [WORD_W-1:0] ld_data
);
  acc_size_e  sz_q;
  logic       uns_q;
  logic [1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      sz_q     <= SZ_WORD;
      uns_q    <= 1'b0;
      off_q    <= 2'b00;
    end else begin
      ld_valid <= rd_go;
      if (rd_go) begin
        sz_q  <= req_size;
        uns_q <= req_unsigned;
        off_q <= off;
      end
    end
  end

  assign ld_data = extract(sz_q, uns_q, off_q, mem_rdata);

  AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> ld_valid); // R7
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !ld_valid); // R9
  AST_ZERO_FILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && uns_q && sz_q == SZ_BYTE) |-> (ld_data[WORD_W-1:8] == '0)); // R8
  AST_ZERO_FILL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && uns_q && sz_q == SZ_HALF) |-> (ld_data[WORD_W-1:16] == '0)); // R8
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic [WORD_W-1:0] store_data,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [LANE_N-1:0] mem_byte_en,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [WORD_W-1:0] ld_data
);
  acc_size_e sz;
  logic      wr_go;
  logic      rd_go;

  assign sz = acc_size_e'(req_size);

  lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(sz),
    .base(base), .disp(disp), .eff_addr(mem_addr), .misalign(misalign)
  );

  assign wr_go = req_valid & req_store & ~misalign;
  assign rd_go = req_valid & ~req_store & ~misalign;
  assign mem_wr_en = wr_go;
  assign mem_rd_en = rd_go;

  lsu_store_steer u_store (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .req_size(sz), .off(mem_addr[1:0]),
    .store_data(store_data), .byte_en(mem_byte_en), .wdata(mem_wdata)
  );

  lsu_load_extract u_load (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .req_size(sz), .req_unsigned(req_unsigned),
    .off(mem_addr[1:0]), .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R6
  AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_rd_en && !mem_wr_en && mem_byte_en == '0)); // R3
endmodule

// File: tb/lsu_align_unit_bench.sv
module lsu_align_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] base = '0, store_data = '0, mem_rdata = '0;
  logic [15:0] disp = '0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic        mem_rd_en, mem_wr_en, misalign, ld_valid;
  logic [3:0]  mem_byte_en;

  int vectors = 0;
  int fails = 0;

  // Pending load from previous cycle (reference model state).
  bit         p_v = 0;
  int         p_sz = 0;
  bit         p_uns = 0;
  int         p_off = 0;

  always #2.5 clk = ~clk;

  lsu_align_unit u_lsu_align_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .disp(disp),
    .store_data(store_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_byte_en(mem_byte_en),
    .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: byte k of word w, k=0 is the most significant byte.
  function automatic longint byte_at(logic [31:0] w, int k);
    return (longint'(w) >> (8 * (3 - k))) & 255;
  endfunction

  // One cycle: drive at negedge, compare, then let the clock edge pass.
  task automatic step(bit v, bit st, int sz, bit uns, logic [31:0] b, logic [15:0] d,
                      logic [31:0] sd, logic [31:0] rd);
    longint ea;
    int off;
    bit mis, e_rd, e_wr;
    logic [3:0] e_be;
    logic [31:0] e_wd, e_ld;
    longint val;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz[1:0]; req_unsigned = uns;
    base = b; disp = d; store_data = sd; mem_rdata = rd;
    #1;
    ea = (longint'(b) + longint'($signed(d))) & 64'hFFFF_FFFF;
    off = int'(ea % 4);
    if (sz == 0) mis = 0;
    else if (sz == 1) mis = (off % 2) != 0;
    else mis = off != 0;
    mis = mis && v;
    e_wr = v && st && !mis;
    e_rd = v && !st && !mis;
    e_be = 4'b0000;
    if (e_wr) begin
      for (int k = 0; k < 4; k++) begin
        bit on;
        if (sz == 0) on = (k == off);
        else if (sz == 1) on = (k / 2) == (off / 2);
        else on = 1;
        if (on) e_be[3 - k] = 1'b1;
      end
    end
    if (sz == 0) e_wd = sd[7:0] * 32'h0101_0101;
    else if (sz == 1) e_wd = sd[15:0] * 32'h0001_0001;
    else e_wd = sd;

    chk("R1 mem_addr", mem_addr, ea[31:0]);
    chk("R2 misalign", {31'b0, misalign}, {31'b0, mis});
    chk("R3 mem_wr_en", {31'b0, mem_wr_en}, {31'b0, e_wr});
    chk("R4 mem_byte_en", {28'b0, mem_byte_en}, {28'b0, e_be});
    if (e_wr) chk("R5 mem_wdata", mem_wdata, e_wd);
    chk("R6 mem_rd_en", {31'b0, mem_rd_en}, {31'b0, e_rd});

    // Result of the load issued in the previous cycle.
    chk(p_v ? "R7 ld_valid" : "R9 ld_valid", {31'b0, ld_valid}, {31'b0, p_v});
    if (p_v) begin
      if (p_sz == 0) begin
        val = byte_at(rd, p_off);
        if (!p_uns && val >= 128) val = val - 256;
      end else if (p_sz == 1) begin
        val = byte_at(rd, p_off) * 256 + byte_at(rd, p_off + 1);
        if (!p_uns && val >= 32768) val = val - 65536;
      end else val = longint'(rd);
      e_ld = val[31:0];
      chk(p_uns ? "R8 R7 ld_data zero-extended" : "R8 R7 ld_data sign-extended", ld_data, e_ld);
    end
    p_v = e_rd; p_sz = sz; p_uns = uns; p_off = off;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 ld_valid after reset", {31'b0, ld_valid}, 32'd0);

    // R7 R8: byte loads at every offset, signed then unsigned.
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, 0, 32'h0000_1000, 16'(k), '0, 32'h8091_A2F3);
      step(1, 0, 0, 1, 32'h0000_1000, 16'(k), '0, 32'h8091_A2F3);
    end
    // Halfword loads at both aligned offsets.
    for (int k = 0; k < 4; k += 2) begin
      step(1, 0, 1, 0, 32'h0000_2000, 16'(k), '0, 32'h85C3_F00F);
      step(1, 0, 1, 1, 32'h0000_2000, 16'(k), '0, 32'hF4E2_9177);
    end
    step(1, 0, 2, 0, 32'h0000_3000, 16'h0004, '0, 32'hDEAD_BEEF);
    step(1, 0, 2, 1, 32'h0000_3000, 16'h0008, '0, 32'hCAFE_0001);
    step(0, 0, 0, 0, '0, '0, '0, 32'h1234_5678); // R7 word unsigned result here

    // R4 R5: stores at every offset and size.
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 32'h0000_4000, 16'(k), 32'h1122_33A5, '0);
    step(1, 1, 1, 0, 32'h0000_4000, 16'h0000, 32'h1122_B3C4, '0);
    step(1, 1, 1, 0, 32'h0000_4000, 16'h0002, 32'h1122_B3C4, '0);
    step(1, 1, 2, 0, 32'h0000_4000, 16'h0000, 32'h89AB_CDEF, '0);
    step(1, 1, 3, 0, 32'h0000_4000, 16'h0004, 32'h0BAD_F00D, '0);

    // R2 R3 R9: misaligned halfword and word accesses, loads and stores.
    step(1, 0, 1, 0, 32'h0000_5001, '0, '0, '0);
    step(1, 1, 1, 0, 32'h0000_5003, '0, 32'hFFFF_FFFF, '0);
    for (int k = 1; k < 4; k++) begin
      step(1, 0, 2, 0, 32'h0000_6000, 16'(k), '0, 32'hFFFF_FFFF);
      step(1, 1, 2, 0, 32'h0000_6000, 16'(k), 32'h5555_AAAA, 32'hFFFF_FFFF);
      step(1, 0, 3, 0, 32'h0000_6000, 16'(k), '0, 32'hFFFF_FFFF);
    end
    step(0, 0, 2, 0, 32'h0000_0001, '0, '0, '0); // idle with odd address: no flag

    // R1: negative displacements, wrap below zero and past the top.
    step(1, 0, 2, 0, 32'h0000_0000, 16'hFFFC, '0, '0);
    step(1, 0, 0, 0, 32'h0001_0000, 16'h8000, '0, 32'h0000_0080);
    step(1, 1, 0, 0, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0077, 32'h0000_0080);
    step(1, 0, 1, 0, 32'hFFFF_FFF0, 16'h7FFE, '0, '0);

    // Mixed random traffic.
    for (int n = 0; n < 600; n++) begin
      logic [31:0] rb;
      logic [15:0] rdsp;
      rb = $urandom;
      rdsp = 16'($urandom);
      step(($urandom % 8) != 0, $urandom % 2, int'($urandom % 4), $urandom % 2,
           rb, rdsp, $urandom, $urandom);
    end
    step(0, 0, 0, 0, '0, '0, '0, 32'h8000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule